// File: doc/BRIEF.md
# System Configuration Register Bank

This block is a small memory-mapped configuration bank on a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Software uses it to set four things:

- which memory appears at address zero;
- one peripheral mode bit;
- for each of sixteen interrupt lines, which GPIO port feeds it;
- whether the I/O compensation cell is enabled. A read-only flag reports when that cell is ready.

The bank drives its outputs straight from the stored fields. The address-zero alias select goes to the memory decoder. The routed interrupt lines go to the edge detector of the interrupt controller. The enable goes to the analog compensation cell, and the cell's ready signal comes back into the bank. On reset, the remap field loads whatever the boot pins present. Every other field resets to zero. Writes take effect on the clock edge that samples the write strobe. Reads return the stored state in the same cycle as the address.

Top module: `sys_cfg_bank`

## Requirements
- R1: Fields sit at fixed byte addresses and bit positions.
  - Remap select: 0x00, bits 1:0.
  - Peripheral mode: 0x04, bit 16.
  - Source selectors: 0x08, 0x0C, 0x10 and 0x14. Line x uses register x/4 at bits 4*(x mod 4)+3 : 4*(x mod 4).
  - Compensation enable: 0x20, bit 0. Compensation ready: 0x20, bit 8.
  - A write updates the addressed fields at the sampling edge. A read returns them combinationally.
- R2: While reset is held at a clock edge, the remap field loads boot_mode. After reset, software may overwrite it. remap_sel always equals the stored field. The codes are 00 for main flash, 01 for system flash and 11 for embedded SRAM.
- R3: The peripheral mode bit resets to 0, can be read and written at bit 16 of 0x04, and drives periph_mode.
- R4: All source selectors reset to 0000. Line x carries pin x of the selected port, never a pin of another index.
  - The codes are 0000=A, 0001=B, 0010=C, 0011=D, 0100=E and 0111=H.
  - port_pins bit p*16+x is pin x of port slot p. The slots in order are A, B, C, D, E, H.
- R5: A line whose selector holds a reserved or unused code drives 0. These codes are 0101, 0110 and 1000 to 1111.
- R6: Writes to reserved bits of every mapped register are ignored, and those bits read as 0.
- R7: Any other address, including 0x18, 0x1C and addresses that are not word aligned, reads as 0. A write to such an address changes no state.
- R8: The compensation enable resets to 0, can be read and written at bit 0 of 0x20, and drives comp_enable.
- R9: The ready flag (bit 8 of 0x20, and comp_ready) is read-only. It is 1 only while the enable is 1 and comp_rdy_async has passed through a two-flop synchroniser. An edge of comp_rdy_async therefore shows up two clock edges later.
- R10: The ready flag clears in the same cycle in which the enable bit reads 0. This means it is already 0 right after the edge that writes the enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mode | input | 2 | Boot pin value loaded into the remap field during reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| remap_sel | output | 2 | Address-zero alias select |
| periph_mode | output | 1 | Peripheral mode control bit |
| port_pins | input | 96 | Six GPIO ports of 16 pins, slot p at bits p*16+15:p*16 |
| irq_line | output | 16 | Routed interrupt lines |
| comp_enable | output | 1 | Compensation cell enable |
| comp_rdy_async | input | 1 | Asynchronous ready from the compensation cell |
| comp_ready | output | 1 | Synchronised and gated ready flag |

## Verification
Register fields are due on the first clock edge after the write strobe is sampled. The bench drives every write on a falling edge and reads back only after the next falling edge. Read data and routed interrupt lines are combinational, so they are sampled one nanosecond after the address or pins change, without waiting for a clock. The ready flag depends on exactly two edges after a change of the cell's ready input. The bench samples it after one edge, when it must still hold its old value, and again after the second edge, when it must have changed. It checks the drop on disable right after the edge that writes the enable bit.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;
   localparam int DATA_W        = 32;
   localparam int CODE_W        = 4;
   localparam int LINES_PER_REG = 4;
   localparam int NUM_PORTS     = 6;
   localparam int REMAP_W       = 2;

   localparam int OFF_REMAP     = 'h00;
   localparam int OFF_PMODE     = 'h04;
   localparam int OFF_SRC_BASE  = 'h08;
   localparam int OFF_COMP      = 'h20;
   localparam int REG_STRIDE    = 4;

   localparam int PMODE_BIT     = 16;
   localparam int COMP_EN_BIT   = 0;
   localparam int COMP_RDY_BIT  = 8;
   localparam int SRC_FIELD_W   = LINES_PER_REG * CODE_W;

   typedef enum logic [CODE_W-1:0] {
      SRC_A = 4'd0,
      SRC_B = 4'd1,
      SRC_C = 4'd2,
      SRC_D = 4'd3,
      SRC_E = 4'd4,
      SRC_H = 4'd7
   } src_code_e;

   function automatic logic code_valid(input logic [CODE_W-1:0] c);
      return (c <= 4'd4) || (c == 4'd7);
   endfunction
endpackage

// File: rtl/sys_cfg_line_mux.sv
module sys_cfg_line_mux
   import sys_cfg_pkg::*;
(
   input  logic [CODE_W-1:0]    code,
   input  logic [NUM_PORTS-1:0] pins,
   output logic                 line
);
   // pins holds one pin of a single index taken from each port slot,
   // so whatever the code, the line never sees a pin of another index.
   always_comb begin
      line = 1'b0;
      case (code)
         SRC_A:   line = pins[0];
         SRC_B:   line = pins[1];
         SRC_C:   line = pins[2];
         SRC_D:   line = pins[3];
         SRC_E:   line = pins[4];
         SRC_H:   line = pins[5];
         default: line = 1'b0;
      endcase
   end
endmodule

// File: rtl/sys_cfg_comp_ready.sv
module sys_cfg_comp_ready #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic rdy_async,
   output logic ready
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("sys_cfg_comp_ready: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rdy_async};
   end

   // The gate sits after the synchroniser so that the flag drops in the
   // same cycle as the enable does.
   assign ready = enable & sync_q[SYNC_STAGES-1];

   assert_sync_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && ready) |-> $past(sync_q[SYNC_STAGES-2]))
      else $error("ready rose without a synchronised input");
endmodule

// File: rtl/sys_cfg_bank.sv
module sys_cfg_bank
   import sys_cfg_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int NUM_LINES   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [REMAP_W-1:0]             boot_mode,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic                           bus_we,
   input  logic [DATA_W-1:0]              bus_wdata,
   output logic [DATA_W-1:0]              bus_rdata,
   output logic [REMAP_W-1:0]             remap_sel,
   output logic                           periph_mode,
   input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
   output logic [NUM_LINES-1:0]           irq_line,
   output logic                           comp_enable,
   input  logic                           comp_rdy_async,
   output logic                           comp_ready
);
   localparam int NUM_SRC_REGS = NUM_LINES / LINES_PER_REG;
   localparam int SRC_END      = OFF_SRC_BASE + REG_STRIDE * NUM_SRC_REGS;

   // ---------------- elaboration checks ----------------
   if (NUM_LINES % LINES_PER_REG != 0) begin : g_bad_lines
      $error("sys_cfg_bank: NUM_LINES must be a multiple of LINES_PER_REG");
   end
   if (SRC_END > OFF_COMP) begin : g_bad_map
      $error("sys_cfg_bank: source registers overlap the compensation register");
   end
   if ((1 << ADDR_W) <= OFF_COMP) begin : g_bad_addr
      $error("sys_cfg_bank: ADDR_W too narrow for the register map");
   end
   if (SRC_FIELD_W > PMODE_BIT) begin : g_bad_field
      $error("sys_cfg_bank: source fields would overrun reserved bits");
   end

   // ---------------- address decode ----------------
   logic                    hit_remap, hit_pmode, hit_comp;
   logic [NUM_SRC_REGS-1:0] hit_src;

   assign hit_remap = (bus_addr == ADDR_W'(OFF_REMAP));
   assign hit_pmode = (bus_addr == ADDR_W'(OFF_PMODE));
   assign hit_comp  = (bus_addr == ADDR_W'(OFF_COMP));

   for (genvar r = 0; r < NUM_SRC_REGS; r++) begin : g_src_dec
      assign hit_src[r] = (bus_addr == ADDR_W'(OFF_SRC_BASE + REG_STRIDE * r));
   end

   // ---------------- storage ----------------
   logic [REMAP_W-1:0]                remap_q;
   logic                              pmode_q;
   logic                              comp_en_q;
   logic [NUM_LINES-1:0][CODE_W-1:0]  src_code;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remap_q   <= boot_mode;
         pmode_q   <= 1'b0;
         comp_en_q <= 1'b0;
         src_code  <= '0;
      end else if (bus_we) begin
         if (hit_remap) remap_q   <= bus_wdata[REMAP_W-1:0];
         if (hit_pmode) pmode_q   <= bus_wdata[PMODE_BIT];
         if (hit_comp)  comp_en_q <= bus_wdata[COMP_EN_BIT];
         for (int r = 0; r < NUM_SRC_REGS; r++) begin
            if (hit_src[r]) begin
               for (int k = 0; k < LINES_PER_REG; k++) begin
                  src_code[r*LINES_PER_REG + k] <= bus_wdata[k*CODE_W +: CODE_W];
               end
            end
         end
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   assign remap_sel   = remap_q;
   assign periph_mode = pmode_q;
   assign comp_enable = comp_en_q;

   // ---------------- compensation ready ----------------
   sys_cfg_comp_ready #(
      .SYNC_STAGES (SYNC_STAGES)
   ) i_comp_ready (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (comp_en_q),
      .rdy_async (comp_rdy_async),
      .ready     (comp_ready)
   );

   // ---------------- interrupt line routing ----------------
   for (genvar x = 0; x < NUM_LINES; x++) begin : g_line
      logic [NUM_PORTS-1:0] column;
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
         assign column[p] = port_pins[p*NUM_LINES + x];
      end

      sys_cfg_line_mux i_mux (
         .code (src_code[x]),
         .pins (column),
         .line (irq_line[x])
      );

      assert_reserved_code_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !code_valid(src_code[x]) |-> !irq_line[x])
         else $error("line driven by a reserved source code");
   end

   // ---------------- read path ----------------
   always_comb begin
      bus_rdata = '0;
      if (hit_remap) bus_rdata[REMAP_W-1:0] = remap_q;
      if (hit_pmode) bus_rdata[PMODE_BIT]   = pmode_q;
      if (hit_comp) begin
         bus_rdata[COMP_EN_BIT]  = comp_en_q;
         bus_rdata[COMP_RDY_BIT] = comp_ready;
      end
      for (int r = 0; r < NUM_SRC_REGS; r++) begin
         if (hit_src[r]) bus_rdata[SRC_FIELD_W-1:0] = src_code[r*LINES_PER_REG +: LINES_PER_REG];
      end
   end

   // ---------------- assertions ----------------
   assert_remap_boot_R2: assert property (@(posedge clk)
      $rose(rst_n) |-> (remap_sel == $past(boot_mode)))
      else $error("remap did not load boot pins");

   assert_pmode_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_pmode) |=> (periph_mode == $past(bus_wdata[PMODE_BIT])))
      else $error("peripheral mode write lost");

   assert_comp_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_comp |-> ((bus_rdata & ~((32'd1 << COMP_RDY_BIT) | (32'd1 << COMP_EN_BIT))) == '0))
      else $error("reserved compensation bits read nonzero");

   assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_remap || hit_pmode || hit_comp || (|hit_src)) |-> (bus_rdata == '0))
      else $error("unmapped address returned data");

   assert_ready_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !comp_enable |-> !comp_ready)
      else $error("ready flag set while disabled");

   assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_comp && !bus_wdata[COMP_EN_BIT]) |=> !comp_ready)
      else $error("ready flag outlived its enable");
endmodule

// File: tb/test_sys_cfg_bank.sv
module test_sys_cfg_bank;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   boot_mode = 2'b11;
   logic [7:0]   bus_addr = '0;
   logic         bus_we = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [1:0]   remap_sel;
   logic         periph_mode;
   logic [95:0]  port_pins = '0;
   logic [15:0]  irq_line;
   logic         comp_enable;
   logic         comp_rdy_async = 1'b0;
   logic         comp_ready;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   sys_cfg_bank i_sys_cfg_bank (
      .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .remap_sel(remap_sel), .periph_mode(periph_mode),
      .port_pins(port_pins), .irq_line(irq_line),
      .comp_enable(comp_enable), .comp_rdy_async(comp_rdy_async), .comp_ready(comp_ready)
   );

   // {address, write data, expected readback}
   localparam logic [71:0] VEC [12] = '{
      {8'h00, 32'hFFFF_FFFF, 32'h0000_0003},
      {8'h00, 32'h0000_0001, 32'h0000_0001},
      {8'h04, 32'hFFFF_FFFF, 32'h0001_0000},
      {8'h04, 32'hFFFE_FFFF, 32'h0000_0000},
      {8'h04, 32'h0001_0000, 32'h0001_0000},
      {8'h08, 32'hABCD_3210, 32'h0000_3210},
      {8'h0C, 32'h1234_7744, 32'h0000_7744},
      {8'h10, 32'hFFFF_0123, 32'h0000_0123},
      {8'h14, 32'h0000_FEDC, 32'h0000_FEDC},
      {8'h20, 32'hFFFF_FFFE, 32'h0000_0000},
      {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},
      {8'h1C, 32'hFFFF_FFFF, 32'h0000_0000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [3:0] code_of(input int cfg, input int x);
      case (cfg)
         0: return 4'(x % 8);
         1: return 4'(8 + (x % 8));
         2: return 4'd7;
         default: return 4'((x * 3) % 5);
      endcase
   endfunction

   function automatic logic [15:0] exp_lines(input int cfg, input logic [95:0] p);
      logic [15:0] e;
      for (int x = 0; x < 16; x++) begin
         case (code_of(cfg, x))
            4'd0: e[x] = p[0*16 + x];
            4'd1: e[x] = p[1*16 + x];
            4'd2: e[x] = p[2*16 + x];
            4'd3: e[x] = p[3*16 + x];
            4'd4: e[x] = p[4*16 + x];
            4'd7: e[x] = p[5*16 + x];
            default: e[x] = 1'b0;
         endcase
      end
      return e;
   endfunction

   task automatic do_reset(input logic [1:0] boot);
      @(negedge clk);
      rst_n = 1'b0; boot_mode = boot;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      boot_mode = ~boot;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [95:0] pat;

      // Reset state
      do_reset(2'b11);
      #1;
      chk("R2 remap_sel after reset boot=11", 32'(remap_sel), 32'h3);
      rd(8'h00, d); chk("R2 remap read after reset", d, 32'h3);
      rd(8'h04, d); chk("R3 pmode reset", d, 32'h0);
      for (int r = 0; r < 4; r++) begin
         rd(8'(8 + 4*r), d); chk("R4 source reg reset", d, 32'h0);
      end
      rd(8'h20, d); chk("R8 comp reset", d, 32'h0);
      chk("R8 comp_enable reset", 32'(comp_enable), 32'h0);
      #1 chk("R4 lines zero with idle pins", 32'(irq_line), 32'h0);

      // Vector walk: write, then read back
      foreach (VEC[i]) begin
         wr(VEC[i][71:64], VEC[i][63:32]);
         rd(VEC[i][71:64], d);
         chk($sformatf("R1,R6,R7 vector %0d", i), d, VEC[i][31:0]);
      end
      chk("R2 remap_sel after write", 32'(remap_sel), 32'h1);
      chk("R3 periph_mode output", 32'(periph_mode), 32'h1);

      // Unmapped and misaligned writes leave state alone
      wr(8'h01, 32'hFFFF_FFFF);
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h0A, 32'h0000_0000);
      rd(8'h00, d); chk("R7 remap untouched", d, 32'h1);
      rd(8'h04, d); chk("R7 pmode untouched", d, 32'h0001_0000);
      rd(8'h08, d); chk("R7 source untouched", d, 32'h0000_3210);
      rd(8'h20, d); chk("R7 comp untouched", d, 32'h0);
      rd(8'h01, d); chk("R7 misaligned read zero", d, 32'h0);
      rd(8'h30, d); chk("R7 high unmapped read zero", d, 32'h0);

      // Routing under several code configurations and pin patterns
      for (int cfg = 0; cfg < 4; cfg++) begin
         for (int r = 0; r < 4; r++) begin
            wr(8'(8 + 4*r), {16'hFFFF, code_of(cfg, 4*r+3), code_of(cfg, 4*r+2),
                             code_of(cfg, 4*r+1), code_of(cfg, 4*r)});
         end
         for (int k = 0; k < 5; k++) begin
            case (k)
               0: pat = '1;
               1: pat = {6{16'hA5C3}};
               2: pat = {6{16'h5A3C}};
               default: pat = {$urandom, $urandom, $urandom};
            endcase
            @(negedge clk); port_pins = pat;
            #1 chk($sformatf("R4,R5 routing cfg %0d pattern %0d", cfg, k),
                   32'(irq_line), 32'(exp_lines(cfg, pat)));
         end
      end

      // Index isolation: only pin 3 of port A high, all lines on port A
      for (int r = 0; r < 4; r++) wr(8'(8 + 4*r), 32'h0);
      @(negedge clk); port_pins = 96'h0; port_pins[3] = 1'b1;
      #1 chk("R4 index isolation port A", 32'(irq_line), 32'h0008);
      for (int r = 0; r < 4; r++) wr(8'(8 + 4*r), 32'h7777);
      @(negedge clk); port_pins = 96'h0; port_pins[5*16 + 9] = 1'b1;
      #1 chk("R4 index isolation port H", 32'(irq_line), 32'h0200);
      for (int r = 0; r < 4; r++) wr(8'(8 + 4*r), 32'h6565);
      @(negedge clk); port_pins = '1;
      #1 chk("R5 reserved codes 5 and 6 low", 32'(irq_line), 32'h0);

      // Ready flag: gated by enable
      @(negedge clk); comp_rdy_async = 1'b1;
      repeat (3) @(negedge clk);
      rd(8'h20, d); chk("R9 ready masked while disabled", d, 32'h0);
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h20, d); chk("R9 ready with enable", d, 32'h0000_0101);
      chk("R8 comp_enable set", 32'(comp_enable), 32'h1);

      // Ready follows input after two edges
      @(negedge clk); comp_rdy_async = 1'b0;
      @(negedge clk); #1 chk("R9 ready holds after one edge", 32'(comp_ready), 32'h1);
      @(negedge clk); #1 chk("R9 ready drops after two edges", 32'(comp_ready), 32'h0);
      @(negedge clk); comp_rdy_async = 1'b1;
      @(negedge clk); #1 chk("R9 ready low after one edge", 32'(comp_ready), 32'h0);
      @(negedge clk); #1 chk("R9 ready high after two edges", 32'(comp_ready), 32'h1);
      wr(8'h20, 32'h0000_0100);
      #1 chk("R10 ready clears with enable", 32'(comp_ready), 32'h0);
      chk("R10 comp_enable cleared", 32'(comp_enable), 32'h0);
      rd(8'h20, d); chk("R10 comp read after disable", d, 32'h0);

      // Second reset with a different boot value
      do_reset(2'b01);
      #1 chk("R2 remap_sel boot=01", 32'(remap_sel), 32'h1);
      rd(8'h00, d); chk("R2 remap held after boot pins change", d, 32'h1);
      rd(8'h14, d); chk("R4 source cleared by reset", d, 32'h0);

      finish_run();
   end
endmodule